// File: doc/BRIEF.md
# Bit-Sliced Expert Weight Cache Controller

This block keeps the residency bookkeeping for a small region of memory that holds expert weights split into two precision slices: a high-order slice that every use of an expert needs, and a low-order slice that is added only when full precision is wanted. Requests arrive one at a time with a valid/ready handshake. Each request carries an expert index, a gating score and a flag that closes the current batch. For each request the block reports whether each slice it looked up was resident. For each slice that was absent it raises a fetch indication towards a slower backing store, and it marks that slice resident straight away.

Capacity is counted in slices. When an accepted request pushes the resident count above the capacity parameter, the block stops accepting requests and evicts one slice per cycle. Low-order slices go first, least recently used first. The least recently used high-order slice goes only when no low-order slice is left. The block also counts slice lookups and slice misses over a batch. When a batch closes with a miss rate above a percentage target, it sheds every resident low-order slice. Each eviction is reported with the expert index and the slice type, so that an outer agent can free the storage.

Top module: `bsx_cache_ctrl`

## Requirements
- R1: Every accepted request looks up the high-order slice of its expert. One cycle after acceptance `rsp_valid` is 1 and exactly one of `rsp_msb_hit` and `fetch_msb` is 1. After a miss the slice is resident.
- R2: The low-order slice is looked up only when `req_score` is strictly greater than `lsb_thresh`. When the score is equal to or below the threshold, `rsp_lsb_req`, `rsp_lsb_hit` and `fetch_lsb` are all 0 and low-order residency is left unchanged. When the score is above the threshold, `rsp_lsb_req` is 1 and a missing low-order slice is fetched and made resident.
- R3: When a high-order slice must be evicted, the victim is the resident high-order slice whose last lookup is the oldest.
- R4: While any low-order slice is resident, every eviction removes a low-order slice, and the victim is the one whose last lookup is the oldest.
- R5: A low-order slice is never resident without the high-order slice of the same expert. Evicting a high-order slice also drops that expert's low-order slice.
- R6: Hits are reported separately for the two slices: `rsp_lsb_hit` is 1 exactly when the low-order slice was looked up and found resident.
- R7: When an accepted request leaves more than CAP slices resident, `req_ready` stays 0 while the block evicts one slice per cycle. It evicts until at most CAP slices remain, and `req_ready` returns to 1 only with at most CAP slices resident.
- R8: Every looked-up slice counts one access, and every absent slice counts one miss. A request with `req_eob`=1 closes the batch and is counted in it. If misses×100 > `target_pct`×accesses for that batch, `rsp_rate_over` is 1 and all resident low-order slices are evicted, least recently used first. Both counters restart at zero after the closing request.
- R9: Each eviction is reported for one cycle with `ev_valid`=1, `ev_id` set to the expert index, and `ev_lsb`=1 for a low-order slice or 0 for a high-order slice. `req_ready` is 0 in that cycle.
- R10: After reset `req_ready` is 1, `rsp_valid` and `ev_valid` are 0, and no slice is resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (no eviction in progress) |
| req_id | input | $clog2(N_EXP) | Expert index |
| req_score | input | SCORE_W | Gating score of this expert for the request |
| req_eob | input | 1 | Request closes the current batch |
| lsb_thresh | input | SCORE_W | Score that must be exceeded to use the low-order slice |
| target_pct | input | 7 | Batch miss-rate target in percent |
| rsp_valid | output | 1 | Lookup result for the request accepted in the previous cycle |
| rsp_id | output | $clog2(N_EXP) | Expert index of the result |
| rsp_msb_hit | output | 1 | High-order slice was resident |
| rsp_lsb_req | output | 1 | Low-order slice was looked up |
| rsp_lsb_hit | output | 1 | Low-order slice was looked up and resident |
| rsp_rate_over | output | 1 | Closing request of a batch whose miss rate exceeded the target |
| fetch_msb | output | 1 | Load the high-order slice of `rsp_id` from backing store |
| fetch_lsb | output | 1 | Load the low-order slice of `rsp_id` from backing store |
| ev_valid | output | 1 | A slice was evicted |
| ev_id | output | $clog2(N_EXP) | Expert index of the evicted slice |
| ev_lsb | output | 1 | Evicted slice type: 1 low-order, 0 high-order |

## Verification
The hardest state to reach from the ports is a high-order eviction. It needs more distinct experts than the capacity to be touched while no low-order slice survives. The bench reaches it with runs of low-score requests over more experts than CAP, using a small configuration of four experts and capacity three. The miss-rate shedding path needs batches that close over a nonzero target while several low-order slices are resident. A pseudo-random stream interleaves score bands around the threshold with batch ends, and cycles the target through 0, 25, 50 and 100 percent. A bench model built on last-use stamps predicts every response and every eviction in order.

// File: rtl/bsx_pkg.sv
package bsx_pkg;
   typedef enum logic [0:0] {
      ST_SERVE = 1'b0,
      ST_EVICT = 1'b1
   } bsx_state_e;

   typedef struct packed {
      logic msb_hit;
      logic lsb_req;
      logic lsb_hit;
      logic rate_over;
      logic fetch_msb;
      logic fetch_lsb;
   } bsx_rsp_t;
endpackage

// File: rtl/bsx_slice_lru.sv
// Residency and recency for one slice class. Resident entries hold distinct
// ranks 0..k-1, rank 0 being the most recent; the victim has the highest rank.
module bsx_slice_lru #(
   parameter int N  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch_en,
   input  logic [IW-1:0] touch_idx,
   input  logic          drop_en,
   input  logic [IW-1:0] drop_idx,
   output logic [N-1:0]  valid_o,
   output logic [IW-1:0] victim_o
);
   localparam int RW = $clog2(N + 1);

   if (N < 2) begin : g_bad_n
      $error("bsx_slice_lru: N must be at least 2");
   end

   logic [RW-1:0] rank_q [N];
   logic [N-1:0]  vld_q;
   logic [RW-1:0] touch_ref;
   logic [RW-1:0] best;
   logic          found;

   assign valid_o   = vld_q;
   // An absent entry counts as older than every resident one.
   assign touch_ref = vld_q[touch_idx] ? rank_q[touch_idx] : RW'(N);

   always_comb begin
      victim_o = '0;
      best     = '0;
      found    = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (vld_q[i] && (!found || rank_q[i] > best)) begin
            found    = 1'b1;
            best     = rank_q[i];
            victim_o = IW'(i);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int i = 0; i < N; i++) rank_q[i] <= '0;
      end else if (touch_en) begin
         for (int i = 0; i < N; i++) begin
            if (vld_q[i] && IW'(i) != touch_idx && rank_q[i] < touch_ref)
               rank_q[i] <= rank_q[i] + RW'(1);
         end
         rank_q[touch_idx] <= '0;
         vld_q[touch_idx]  <= 1'b1;
      end else if (drop_en && vld_q[drop_idx]) begin
         for (int i = 0; i < N; i++) begin
            if (vld_q[i] && rank_q[i] > rank_q[drop_idx])
               rank_q[i] <= rank_q[i] - RW'(1);
         end
         vld_q[drop_idx] <= 1'b0;
      end
   end
endmodule

// File: rtl/bsx_rate_mon.sv
// Batch access and miss counters with a division-free rate comparison.
module bsx_rate_mon #(
   parameter int CNT_W = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       upd_en,
   input  logic [1:0] acc_add,
   input  logic [1:0] miss_add,
   input  logic       batch_end,
   input  logic [6:0] target_pct,
   output logic       over_o
);
   localparam int PW = CNT_W + 7;

   if (CNT_W < 4) begin : g_bad_cnt
      $error("bsx_rate_mon: CNT_W must be at least 4");
   end

   logic [CNT_W-1:0] acc_q, miss_q, acc_nx, miss_nx;

   assign acc_nx  = acc_q + CNT_W'(acc_add);
   assign miss_nx = miss_q + CNT_W'(miss_add);
   assign over_o  = upd_en && batch_end &&
                    (PW'(miss_nx) * PW'(100) > PW'(target_pct) * PW'(acc_nx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         miss_q <= '0;
      end else if (upd_en) begin
         acc_q  <= batch_end ? '0 : acc_nx;
         miss_q <= batch_end ? '0 : miss_nx;
      end
   end
endmodule

// File: rtl/bsx_cache_ctrl.sv
module bsx_cache_ctrl
   import bsx_pkg::*;
#(
   parameter int N_EXP   = 8,
   parameter int SCORE_W = 8,
   parameter int CAP     = 12,
   parameter int CNT_W   = 16,
   localparam int IW     = $clog2(N_EXP)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [IW-1:0]      req_id,
   input  logic [SCORE_W-1:0] req_score,
   input  logic               req_eob,
   input  logic [SCORE_W-1:0] lsb_thresh,
   input  logic [6:0]         target_pct,
   output logic               rsp_valid,
   output logic [IW-1:0]      rsp_id,
   output logic               rsp_msb_hit,
   output logic               rsp_lsb_req,
   output logic               rsp_lsb_hit,
   output logic               rsp_rate_over,
   output logic               fetch_msb,
   output logic               fetch_lsb,
   output logic               ev_valid,
   output logic [IW-1:0]      ev_id,
   output logic               ev_lsb
);
   localparam int OW = $clog2(2 * N_EXP + 1);

   if (N_EXP < 2) begin : g_bad_nexp
      $error("bsx_cache_ctrl: N_EXP must be at least 2");
   end
   if (CAP < 2 || CAP > 2 * N_EXP) begin : g_bad_cap
      $error("bsx_cache_ctrl: CAP must lie in 2..2*N_EXP");
   end
   if (SCORE_W < 1) begin : g_bad_score
      $error("bsx_cache_ctrl: SCORE_W must be positive");
   end

   bsx_state_e    state_q;
   logic          shed_q;
   bsx_rsp_t      rsp_q;
   logic [N_EXP-1:0] msb_vld, lsb_vld;
   logic [IW-1:0] msb_vic, lsb_vic;
   logic          accept, m_hit, l_req, l_hit, rate_over;
   logic          any_lsb, need, fire, msb_drop, lsb_drop;
   logic [OW-1:0] occ_now, occ_acc;

   assign req_ready = (state_q == ST_SERVE);
   assign accept    = req_valid && req_ready;
   assign m_hit     = msb_vld[req_id];
   assign l_req     = req_score > lsb_thresh;
   assign l_hit     = l_req && lsb_vld[req_id];

   assign occ_now = OW'($countones(msb_vld)) + OW'($countones(lsb_vld));
   assign occ_acc = occ_now + OW'(!m_hit) + OW'(l_req && !l_hit);

   assign any_lsb  = |lsb_vld;
   assign need     = (occ_now > OW'(CAP)) || (shed_q && any_lsb);
   assign fire     = (state_q == ST_EVICT) && need;
   assign msb_drop = fire && !any_lsb;
   assign lsb_drop = fire && (any_lsb || lsb_vld[msb_vic]);

   bsx_slice_lru #(.N(N_EXP), .IW(IW)) u_msb_lru (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch_en  (accept),
      .touch_idx (req_id),
      .drop_en   (msb_drop),
      .drop_idx  (msb_vic),
      .valid_o   (msb_vld),
      .victim_o  (msb_vic)
   );

   bsx_slice_lru #(.N(N_EXP), .IW(IW)) u_lsb_lru (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch_en  (accept && l_req),
      .touch_idx (req_id),
      .drop_en   (lsb_drop),
      .drop_idx  (any_lsb ? lsb_vic : msb_vic),
      .valid_o   (lsb_vld),
      .victim_o  (lsb_vic)
   );

   bsx_rate_mon #(.CNT_W(CNT_W)) u_rate (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd_en     (accept),
      .acc_add    (2'd1 + {1'b0, l_req}),
      .miss_add   ({1'b0, !m_hit} + {1'b0, l_req && !l_hit}),
      .batch_end  (req_eob),
      .target_pct (target_pct),
      .over_o     (rate_over)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_SERVE;
         shed_q    <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_id    <= '0;
         rsp_q     <= '0;
         ev_valid  <= 1'b0;
         ev_id     <= '0;
         ev_lsb    <= 1'b0;
      end else begin
         rsp_valid <= accept;
         if (accept) begin
            rsp_id          <= req_id;
            rsp_q.msb_hit   <= m_hit;
            rsp_q.lsb_req   <= l_req;
            rsp_q.lsb_hit   <= l_hit;
            rsp_q.rate_over <= rate_over;
            rsp_q.fetch_msb <= !m_hit;
            rsp_q.fetch_lsb <= l_req && !l_hit;
         end
         ev_valid <= fire;
         if (fire) begin
            ev_id  <= any_lsb ? lsb_vic : msb_vic;
            ev_lsb <= any_lsb;
         end
         case (state_q)
            ST_SERVE: if (accept && (occ_acc > OW'(CAP) || rate_over)) begin
               state_q <= ST_EVICT;
               shed_q  <= rate_over;
            end
            default: if (!need) begin
               state_q <= ST_SERVE;
               shed_q  <= 1'b0;
            end
         endcase
      end
   end

   assign rsp_msb_hit   = rsp_q.msb_hit;
   assign rsp_lsb_req   = rsp_q.lsb_req;
   assign rsp_lsb_hit   = rsp_q.lsb_hit;
   assign rsp_rate_over = rsp_q.rate_over;
   assign fetch_msb     = rsp_q.fetch_msb;
   assign fetch_lsb     = rsp_q.fetch_lsb;
endmodule

// File: rtl/bsx_cache_ctrl_chk.sv
module bsx_cache_ctrl_chk #(
   parameter int N_EXP = 8,
   parameter int CAP   = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic             rsp_msb_hit,
   input logic             rsp_lsb_req,
   input logic             rsp_lsb_hit,
   input logic             fetch_msb,
   input logic             fetch_lsb,
   input logic             ev_valid,
   input logic             ev_lsb,
   input logic [N_EXP-1:0] msb_vld,
   input logic [N_EXP-1:0] lsb_vld
);
   int occ;
   assign occ = $countones(msb_vld) + $countones(lsb_vld);

   // R1
   a_r1_one_msb_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_msb_hit != fetch_msb));
   // R2
   a_r2_lsb_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_lsb_req) |-> (!rsp_lsb_hit && !fetch_lsb));
   // R4
   a_r4_lsb_first: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && !ev_lsb) |-> ($past(lsb_vld) == '0));
   // R5
   a_r5_lsb_needs_msb: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> ((lsb_vld & ~msb_vld) == '0));
   // R7
   a_r7_ready_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (occ <= CAP));
   // R9
   a_r9_evict_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid |-> !req_ready);
   // R1
   a_r1_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && req_ready));
endmodule

bind bsx_cache_ctrl bsx_cache_ctrl_chk #(.N_EXP(N_EXP), .CAP(CAP)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .rsp_valid   (rsp_valid),
   .rsp_msb_hit (rsp_msb_hit),
   .rsp_lsb_req (rsp_lsb_req),
   .rsp_lsb_hit (rsp_lsb_hit),
   .fetch_msb   (fetch_msb),
   .fetch_lsb   (fetch_lsb),
   .ev_valid    (ev_valid),
   .ev_lsb      (ev_lsb),
   .msb_vld     (msb_vld),
   .lsb_vld     (lsb_vld)
);

// File: tb/test_bsx_cache_ctrl.sv
`timescale 1ns/1ps
module test_bsx_cache_ctrl;
   localparam int N  = 4;
   localparam int SW = 4;
   localparam int CP = 3;
   localparam int IW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_eob = 1'b0;
   logic [IW-1:0] req_id = '0;
   logic [SW-1:0] req_score = '0;
   logic [SW-1:0] lsb_thresh = 4'd7;
   logic [6:0] target_pct = 7'd100;
   logic req_ready, rsp_valid, rsp_msb_hit, rsp_lsb_req, rsp_lsb_hit;
   logic rsp_rate_over, fetch_msb, fetch_lsb, ev_valid, ev_lsb;
   logic [IW-1:0] rsp_id, ev_id;

   always #5 clk = ~clk;

   bsx_cache_ctrl #(.N_EXP(N), .SCORE_W(SW), .CAP(CP), .CNT_W(16)) i_bsx_cache_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_id(req_id), .req_score(req_score), .req_eob(req_eob),
      .lsb_thresh(lsb_thresh), .target_pct(target_pct), .rsp_valid(rsp_valid),
      .rsp_id(rsp_id), .rsp_msb_hit(rsp_msb_hit), .rsp_lsb_req(rsp_lsb_req),
      .rsp_lsb_hit(rsp_lsb_hit), .rsp_rate_over(rsp_rate_over),
      .fetch_msb(fetch_msb), .fetch_lsb(fetch_lsb), .ev_valid(ev_valid),
      .ev_id(ev_id), .ev_lsb(ev_lsb));

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // Model: residency plus last-use stamps; the oldest stamp is the victim.
   bit mv[N], lv[N];
   int mts[N], lts[N];
   int now = 0, acc = 0, miss = 0;
   int xid[8];
   bit xlsb[8];
   int nx;

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int occ();
      int c = 0;
      for (int i = 0; i < N; i++) c += int'(mv[i]) + int'(lv[i]);
      return c;
   endfunction

   function automatic bit any_l();
      for (int i = 0; i < N; i++) if (lv[i]) return 1'b1;
      return 1'b0;
   endfunction

   task automatic do_req(int id, int sc, bit eob);
      bit e_mhit, e_lreq, e_lhit, e_over;
      int seen, guard, v;
      string etag;
      now++;
      e_mhit = mv[id];
      acc++;
      if (!e_mhit) miss++;
      mv[id] = 1'b1; mts[id] = now;
      e_lreq = (sc > int'(lsb_thresh));
      e_lhit = e_lreq && lv[id];
      if (e_lreq) begin
         acc++;
         if (!e_lhit) miss++;
         lv[id] = 1'b1; lts[id] = now;
      end
      e_over = eob && (miss * 100 > int'(target_pct) * acc);
      if (eob) begin acc = 0; miss = 0; end
      nx = 0;
      while (occ() > CP || (e_over && any_l())) begin
         v = -1;
         if (any_l()) begin
            for (int i = 0; i < N; i++) if (lv[i] && (v < 0 || lts[i] < lts[v])) v = i;
            lv[v] = 1'b0; xlsb[nx] = 1'b1;
         end else begin
            for (int i = 0; i < N; i++) if (mv[i] && (v < 0 || mts[i] < mts[v])) v = i;
            mv[v] = 1'b0; lv[v] = 1'b0; xlsb[nx] = 1'b0;
         end
         xid[nx] = v; nx++;
      end
      @(negedge clk);
      chk("R7 ready before request", int'(req_ready), 1);
      req_valid = 1'b1; req_id = IW'(id); req_score = SW'(sc); req_eob = eob;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R1 rsp_valid", int'(rsp_valid), 1);
      chk("R1 rsp_id", int'(rsp_id), id);
      chk("R1 rsp_msb_hit", int'(rsp_msb_hit), int'(e_mhit));
      chk("R1 fetch_msb", int'(fetch_msb), int'(!e_mhit));
      chk("R2 rsp_lsb_req", int'(rsp_lsb_req), int'(e_lreq));
      chk("R6 rsp_lsb_hit", int'(rsp_lsb_hit), int'(e_lhit));
      chk("R2 fetch_lsb", int'(fetch_lsb), int'(e_lreq && !e_lhit));
      chk("R8 rsp_rate_over", int'(rsp_rate_over), int'(e_over));
      seen = 0; guard = 0;
      while (!req_ready && guard < 40) begin
         if (ev_valid) begin
            if (seen < nx) begin
               etag = xlsb[seen] ? (e_over ? "R8 shed victim" : "R4 lsb victim")
                                 : "R3 msb victim";
               chk({etag, " id"}, int'(ev_id), xid[seen]);
               chk("R9 ev_lsb", int'(ev_lsb), int'(xlsb[seen]));
            end
            seen++;
         end
         @(negedge clk);
         guard++;
      end
      chk("R7 eviction count", seen, nx);
      chk("R9 no eviction when idle", int'(ev_valid), 0);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      int tsel;
      for (int i = 0; i < N; i++) begin mv[i] = 0; lv[i] = 0; mts[i] = 0; lts[i] = 0; end
      repeat (3) @(negedge clk);
      chk("R10 ready after reset", int'(req_ready), 1);
      chk("R10 rsp_valid after reset", int'(rsp_valid), 0);
      chk("R10 ev_valid after reset", int'(ev_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 ready out of reset", int'(req_ready), 1);
      // Directed: hit/miss, threshold boundary, LSB use.
      do_req(0, 0, 0);
      do_req(0, 0, 0);
      do_req(0, 7, 0);   // equal to threshold: no LSB (R2)
      do_req(0, 8, 0);
      do_req(0, 15, 0);
      // LSB evicted first, then MSB LRU evictions (R3, R4).
      do_req(1, 9, 0);
      do_req(2, 0, 0);
      do_req(3, 0, 0);
      do_req(0, 0, 0);
      do_req(1, 0, 1);
      // Shedding on a missed target (R8).
      target_pct = 7'd0;
      do_req(2, 12, 0);
      do_req(2, 12, 1);
      // Pseudo-random sweep over ids, score bands, batch ends and targets.
      lf = 16'hACE1; tsel = 0;
      for (int k = 0; k < 600; k++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         do_req(int'(lf[1:0]), int'(lf[7:4]), lf[10:8] == 3'd0);
         if (lf[10:8] == 3'd0) begin
            tsel = (tsel + 1) % 4;
            target_pct = (tsel == 0) ? 7'd0 : (tsel == 1) ? 7'd25 :
                         (tsel == 2) ? 7'd50 : 7'd100;
         end
      end
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule